// File: doc/BRIEF.md
# Video Raster Beam Position Counter

This block tracks where the electron beam is on the screen for a retro video controller that drives either a 65-cycle-per-line NTSC-style raster or a 71-cycle-per-line PAL-style raster. It keeps a horizontal cycle counter and a vertical line counter. Both advance only on a bus-clock enable. A processor reads the current line number through a small synchronous read port. The line number is split across two byte registers: the line's least significant bit sits alone at the top of one register, and the other register holds the line number divided by two.

The readable line number is not the live counter. It is a snapshot taken at a fixed cycle inside horizontal retrace, and both registers take the snapshot on the same clock. Software that polls the port therefore sees the line advance at a known point in the line and never sees half of an update. The NTSC raster can run interlaced. In that case a field-parity flag alternates from frame to frame, and the field with parity 1 has one extra line at the bottom. The PAL raster ignores the interlace select. A change of standard or of interlace select waits for the next frame boundary before it takes effect. One-clock strobes mark the retrace snapshot and the start of each frame.

Top module: `rasterPosition`

## Requirements
- R1: A line lasts 65 enabled cycles in NTSC mode and 71 in PAL mode. The counters hold still on any clock where `busEn` is low.
- R2: A non-interlaced NTSC frame has 261 lines (0 to 260). The upper register therefore counts 0 to 130, and 130 is only ever seen with line LSB 0.
- R3: A PAL frame has 312 lines. The interlace select has no effect in PAL mode, and `fieldParity` reads 0 throughout.
- R4: With NTSC interlace, `fieldParity` inverts at every frame wrap. A parity-1 field has 263 lines; its last line is upper value 131 with LSB 0. A parity-0 field has 262 lines.
- R5: A read with `rdAddr`=0 returns the line LSB in bit 7 and zeros in bits 6:0. A read with `rdAddr`=1 returns the line number shifted right by one.
- R6: The readable line value takes the current line number on the edge where the cycle counter equals `UPDATE_CYCLE` (default 2) and `busEn` is high. Both registers change on that same edge, and the value holds at every other time.
- R7: `rdData` changes on the clock edge after `rdEn` is sampled high, and holds its value while `rdEn` is low.
- R8: A new standard or interlace select is sampled only at a frame wrap. A frame that is already running keeps the line count and line length it started with.
- R9: `frameStart` is high for exactly one clock, following the enabled edge on which the counters wrap to line 0, cycle 0.
- R10: `lineStrobe` is high for exactly one clock, following the edge that updates the readable line value.
- R11: After reset the counters, the readable value, `rdData`, `fieldParity` and both strobes are 0, and NTSC non-interlaced operation is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Bus-clock enable; the counters advance only when it is high |
| palSel | input | 1 | 1 selects the PAL raster, 0 selects NTSC (sampled at frame wrap) |
| interlaceSel | input | 1 | 1 requests NTSC interlace (sampled at frame wrap) |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 1 | 0 selects the LSB register, 1 selects the upper register |
| rdData | output | 8 | Registered read data |
| lineStrobe | output | 1 | One-clock pulse after the readable line value updates |
| frameStart | output | 1 | One-clock pulse after the wrap to line 0, cycle 0 |
| fieldParity | output | 1 | Field flag; 1 marks the field with the extra line |

## Verification
The read port and the retrace snapshot can land on the same edge. The bench reads on three clocks out of four with the address alternating, so across many lines a read falls on the snapshot edge. For such a read the expected data is the value from before the snapshot. A frame wrap can also coincide with a pending mode change: the bench flips the interlace select and then the standard select in the middle of a frame, and checks that the old line count finishes before the new parity and length apply.

// File: rtl/rasterPkg.sv
package rasterPkg;
  // Strobes passed from the counter control to the readable-value datapath
  typedef struct packed {
    logic updateRead;  // snapshot the line number this edge
    logic frameWrap;   // counters wrap to line 0 cycle 0 this edge
  } rasterStrobeT;
endpackage

// File: rtl/rasterCtrl.sv
module rasterCtrl
  import rasterPkg::*;
#(
  parameter int NTSC_CYCLES  = 65,
  parameter int PAL_CYCLES   = 71,
  parameter int NTSC_LINES   = 261,
  parameter int PAL_LINES    = 312,
  parameter int UPDATE_CYCLE = 2,
  parameter int CYC_W        = 7,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              palSel,
  input  logic              interlaceSel,
  output rasterStrobeT      strobe,
  output logic [LINE_W-1:0] lineNum,
  output logic              fieldParity
);
  logic [CYC_W-1:0]  hCount;
  logic [LINE_W-1:0] vCount;
  logic              activePal;
  logic              activeIl;
  logic              parity;
  logic [CYC_W-1:0]  lineLast;
  logic [LINE_W-1:0] frameLast;
  logic              endLine;
  logic              endFrame;

  always_comb begin
    lineLast = activePal ? CYC_W'(PAL_CYCLES - 1) : CYC_W'(NTSC_CYCLES - 1);
    if (activePal)
      frameLast = LINE_W'(PAL_LINES - 1);
    else if (activeIl)
      frameLast = parity ? LINE_W'(NTSC_LINES + 1) : LINE_W'(NTSC_LINES);
    else
      frameLast = LINE_W'(NTSC_LINES - 1);
  end

  assign endLine  = busEn && (hCount == lineLast);
  assign endFrame = endLine && (vCount == frameLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount    <= '0;
      vCount    <= '0;
      activePal <= 1'b0;
      activeIl  <= 1'b0;
      parity    <= 1'b0;
    end else if (busEn) begin
      if (endLine) begin
        hCount <= '0;
        if (endFrame) begin
          vCount    <= '0;
          activePal <= palSel;
          activeIl  <= interlaceSel && !palSel;
          parity    <= (interlaceSel && !palSel) ? !parity : 1'b0;
        end else begin
          vCount <= vCount + LINE_W'(1);
        end
      end else begin
        hCount <= hCount + CYC_W'(1);
      end
    end
  end

  assign strobe.updateRead = busEn && (hCount == CYC_W'(UPDATE_CYCLE));
  assign strobe.frameWrap  = endFrame;
  assign lineNum           = vCount;
  assign fieldParity       = parity;

  assert_h_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    hCount <= lineLast);
  assert_freeze_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> $stable(hCount) && $stable(vCount));
  assert_v_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    vCount <= frameLast);
  assert_pal_parity_R3: assert property (@(posedge clk) disable iff (!rstN)
    activePal |-> !parity);
  assert_parity_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !endFrame |=> $stable(parity));
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !endFrame |=> $stable(activePal) && $stable(activeIl));
endmodule

// File: rtl/rasterData.sv
module rasterData
  import rasterPkg::*;
#(
  parameter int LINE_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rasterStrobeT      strobe,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              rdEn,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              lineStrobe,
  output logic              frameStart
);
  logic [LINE_W-1:0] visibleLine;
  logic [DATA_W-1:0] lsbReg;
  logic [DATA_W-1:0] upperReg;

  // Single register feeds both views, so they always change together
  always_ff @(posedge clk) begin
    if (!rstN) visibleLine <= '0;
    else if (strobe.updateRead) visibleLine <= lineNum;
  end

  assign lsbReg   = {visibleLine[0], {(DATA_W-1){1'b0}}};
  assign upperReg = DATA_W'(visibleLine >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData     <= '0;
      lineStrobe <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      if (rdEn) rdData <= rdAddr ? upperReg : lsbReg;
      lineStrobe <= strobe.updateRead;
      frameStart <= strobe.frameWrap;
    end
  end

  assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdAddr) |=> (rdData[DATA_W-2:0] == '0));
  assert_vis_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.updateRead |=> $stable(visibleLine));
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
  assert_frame_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);
  assert_line_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    lineStrobe |=> !lineStrobe);
endmodule

// File: rtl/rasterPosition.sv
module rasterPosition
  import rasterPkg::*;
#(
  parameter int NTSC_CYCLES  = 65,
  parameter int PAL_CYCLES   = 71,
  parameter int NTSC_LINES   = 261,
  parameter int PAL_LINES    = 312,
  parameter int UPDATE_CYCLE = 2,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              palSel,
  input  logic              interlaceSel,
  input  logic              rdEn,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              lineStrobe,
  output logic              frameStart,
  output logic              fieldParity
);
  localparam int MAX_LINES  = (PAL_LINES > NTSC_LINES + 2) ? PAL_LINES : NTSC_LINES + 2;
  localparam int MAX_CYCLES = (PAL_CYCLES > NTSC_CYCLES) ? PAL_CYCLES : NTSC_CYCLES;
  localparam int LINE_W     = $clog2(MAX_LINES);
  localparam int CYC_W      = $clog2(MAX_CYCLES);

  rasterStrobeT      strobe;
  logic [LINE_W-1:0] lineNum;

  rasterCtrl #(
    .NTSC_CYCLES(NTSC_CYCLES), .PAL_CYCLES(PAL_CYCLES),
    .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
    .UPDATE_CYCLE(UPDATE_CYCLE), .CYC_W(CYC_W), .LINE_W(LINE_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .palSel(palSel),
    .interlaceSel(interlaceSel), .strobe(strobe), .lineNum(lineNum),
    .fieldParity(fieldParity)
  );

  rasterData #(.LINE_W(LINE_W), .DATA_W(DATA_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineNum(lineNum),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .lineStrobe(lineStrobe), .frameStart(frameStart)
  );
endmodule

// File: tb/tb_rasterPosition.sv
module tb_rasterPosition;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busEn = 1'b0;
  logic       palSel = 1'b0;
  logic       interlaceSel = 1'b0;
  logic       rdEn = 1'b0;
  logic       rdAddr = 1'b0;
  logic [7:0] rdData;
  logic       lineStrobe;
  logic       frameStart;
  logic       fieldParity;

  int checks = 0;
  int failures = 0;
  string curTag = "R11";

  typedef struct {
    bit    rd;
    int    data;
    bit    line;
    bit    frame;
    bit    par;
    string tag;
  } itemT;
  itemT sbq[$];

  // Reference model state, built from the requirements
  int mH = 0, mV = 0, mVis = 0, mRd = 0;
  bit mPal = 0, mIl = 0, mPar = 0;

  always #5 clk = ~clk;

  rasterPosition dut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .palSel(palSel),
    .interlaceSel(interlaceSel), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .lineStrobe(lineStrobe), .frameStart(frameStart),
    .fieldParity(fieldParity)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      if (failures < 30) $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Driver: predicts the outcome of the coming edge and queues it
  task automatic step(bit en, bit rd, bit addr);
    itemT it;
    int lineLen, lineCnt;
    @(negedge clk);
    busEn = en; rdEn = rd; rdAddr = addr;
    if (rd) mRd = addr ? ((mVis >> 1) & 255) : ((mVis & 1) << 7);
    lineLen = mPal ? 71 : 65;
    lineCnt = mPal ? 312 : (mIl ? (mPar ? 263 : 262) : 261);
    it.rd    = rd;
    it.data  = mRd;
    it.line  = en && (mH == 2);
    it.frame = en && (mH == lineLen - 1) && (mV == lineCnt - 1);
    if (en) begin
      if (mH == 2) mVis = mV;
      if (mH == lineLen - 1) begin
        mH = 0;
        if (mV == lineCnt - 1) begin
          mV   = 0;
          mPal = palSel;
          mIl  = interlaceSel && !palSel;
          mPar = mIl ? !mPar : 1'b0;
        end else mV++;
      end else mH++;
    end
    it.par = mPar;
    it.tag = curTag;
    sbq.push_back(it);
  endtask

  task automatic run(int n, bit gated);
    for (int i = 0; i < n; i++)
      step(gated ? (i % 3 != 0) : 1'b1, (i % 4) != 3, i[0]);
  endtask

  // Monitor: pops one expectation per edge and compares
  initial begin
    forever begin
      itemT it;
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        if (it.rd) check(int'(rdData) == it.data, {"R5 R6 read ", it.tag}, rdData, it.data);
        else       check(int'(rdData) == it.data, {"R7 hold ", it.tag}, rdData, it.data);
        if (it.line || lineStrobe)
          check(lineStrobe == it.line, {"R10 lineStrobe ", it.tag}, lineStrobe, it.line);
        if (it.frame || frameStart)
          check(frameStart == it.frame, {"R9 frameStart ", it.tag}, frameStart, it.frame);
        if (it.frame || fieldParity != it.par)
          check(fieldParity == it.par, {"parity ", it.tag}, fieldParity, it.par);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(rdData == 8'd0, "R11 rdData", rdData, 0);
    check(lineStrobe == 1'b0, "R11 lineStrobe", lineStrobe, 0);
    check(frameStart == 1'b0, "R11 frameStart", frameStart, 0);
    check(fieldParity == 1'b0, "R11 fieldParity", fieldParity, 0);
    curTag = "R11";  run(4, 1'b0);
    curTag = "R2";   run(17100, 1'b0);
    interlaceSel = 1'b1;
    curTag = "R8";   run(5000, 1'b0);
    curTag = "R4";   run(40000, 1'b0);
    palSel = 1'b1;
    curTag = "R8";   run(3000, 1'b0);
    curTag = "R3";   run(45000, 1'b0);
    curTag = "R1";   run(6000, 1'b1);
    palSel = 1'b0;
    interlaceSel = 1'b0;
    run(3000, 1'b1);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule